// File: doc/BRIEF.md
# Auxiliary Event Counter Bank with Privilege-Checked Register Access

This block keeps a bank of 64-bit auxiliary event counters and serves the system-register reads and writes that reach it. Each counter counts cycles in which its own event input is high while its own enable is set. Every cycle the block receives a request strobe, a read/write flag, the five register-encoding fields, the current privilege level (0 to 3) and a set of configuration bits. It decides in that same cycle whether the request targets the bank.

For a targeted request the block settles exactly one outcome. A read either returns data or raises a trap towards a higher level with a fixed syndrome class. A write either completes or is reported as an undefined instruction. The trap conditions are resolved in a fixed priority order that depends on the current level. Software at the highest implemented level uses the write path to preload counters. Lower levels read counters only when the trap controls let them.

Top module: `evcnt_bank_ctrl`

## Requirements
- R1: On reset every counter holds zero.
- R2: A request targets the bank only when op0=2'b11, op1=3'b011, CRn=4'b1101 and CRm[3:1]=3'b110. Any other request, and any cycle without the strobe, raises no response output.
- R3: The counter index is the 4-bit value {CRm[0], op2[2:0]}. The read data is the value that counter held before the current clock edge.
- R4: A read at level 0 with user-enable clear traps. The target is level 2 when level 2 is enabled and the route-to-level-2 bit is set, and level 1 otherwise.
- R5: A level-0 read that passes the user-enable check, and any level-1 read, traps to level 2 if level 2 is enabled and the level-2 counter-trap bit is set. Failing that, it traps to level 3 if level 3 is implemented and the level-3 counter-trap bit is set. Otherwise it returns data.
- R6: A level-2 read traps to level 3 only when level 3 is implemented and its counter-trap bit is set. A level-3 read always returns data.
- R7: Every trap reports syndrome class 6'h18 on the class output. The target level is on the 2-bit target output.
- R8: The highest implemented level is 3 if level 3 is implemented, else 2 if level 2 is implemented, else 1. A write at that level completes. A write at any other level flags undefined and changes no counter. Writes are not subject to the trap checks.
- R9: An index at or above NUM_CNT reads as zero, and a write to it completes without effect.
- R10: An enabled counter increments by one after each clock edge at which its event input is high, and wraps at 2^64. A disabled counter keeps its value unless written.
- R11: A completed write to a counter whose enable is set leaves that counter unchanged.
- R12: Each targeted request raises exactly one of read-valid, write-done, trap and undefined, in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level |
| cfg_el2_impl | input | 1 | Level 2 implemented |
| cfg_el3_impl | input | 1 | Level 3 implemented |
| cfg_el2_en | input | 1 | Level 2 enabled for the current context |
| cfg_user_en | input | 1 | Level-0 counter access enable |
| cfg_route_el2 | input | 1 | Route level-0 traps to level 2 |
| cfg_el2_trap | input | 1 | Level-2 counter-trap bit |
| cfg_el3_trap | input | 1 | Level-3 counter-trap bit |
| cnt_enable | input | NUM_CNT | Per-counter enable |
| cnt_event | input | NUM_CNT | Per-counter event input |
| rsp_rdata_vld | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| rsp_wr_done | output | 1 | Write completed |
| rsp_trap | output | 1 | Trap raised |
| rsp_trap_el | output | 2 | Trap target level |
| rsp_trap_ec | output | 6 | Trap syndrome class |
| rsp_undef | output | 1 | Undefined instruction |

## Verification
The assertions assume the configuration is self-consistent. Level 2 is enabled only when it is implemented, and the current level never exceeds the highest implemented level. The bench changes configuration and counter enables only between request cycles, and it chooses the current level of each request from the implemented levels. Write-ignore cases are judged by reading the counter back at level 3. Counting is judged by holding an event high for a known number of edges while no write targets that counter.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned IDX_W  = 4;
  localparam logic [5:0]  TRAP_EC = 6'h18;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_DATA  = 3'd1,
    RSP_WDONE = 3'd2,
    RSP_TRAP  = 3'd3,
    RSP_UNDEF = 3'd4
  } rsp_kind_e;
endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
  import evcnt_pkg::*;
(
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  output logic             bank_hit,
  output logic [IDX_W-1:0] cnt_idx
);
  always_comb begin
    bank_hit = (op0 == 2'b11) && (op1 == 3'b011) && (crn == 4'b1101) &&
               (crm[3:1] == 3'b110);
    cnt_idx  = {crm[0], op2};
  end
endmodule

// File: rtl/evcnt_access_resolve.sv
module evcnt_access_resolve
  import evcnt_pkg::*;
(
  input  logic      req_valid,
  input  logic      bank_hit,
  input  logic      req_write,
  input  logic [1:0] cur_el,
  input  logic      el2_impl,
  input  logic      el3_impl,
  input  logic      el2_en,
  input  logic      user_en,
  input  logic      route_el2,
  input  logic      el2_trap,
  input  logic      el3_trap,
  output rsp_kind_e kind,
  output logic [1:0] trap_el
);
  logic [1:0] top_el;
  logic       l2_hit;
  logic       l3_hit;

  always_comb begin
    top_el  = el3_impl ? 2'd3 : (el2_impl ? 2'd2 : 2'd1);
    l2_hit  = el2_en && el2_trap;
    l3_hit  = el3_impl && el3_trap;
    kind    = RSP_NONE;
    trap_el = 2'd0;
    if (req_valid && bank_hit) begin
      if (req_write) begin
        kind = (cur_el == top_el) ? RSP_WDONE : RSP_UNDEF;
      end else begin
        kind = RSP_DATA;
        unique case (cur_el)
          2'd0: begin
            if (!user_en) begin
              kind = RSP_TRAP; trap_el = (el2_en && route_el2) ? 2'd2 : 2'd1;
            end else if (l2_hit) begin
              kind = RSP_TRAP; trap_el = 2'd2;
            end else if (l3_hit) begin
              kind = RSP_TRAP; trap_el = 2'd3;
            end
          end
          2'd1: begin
            if (l2_hit) begin
              kind = RSP_TRAP; trap_el = 2'd2;
            end else if (l3_hit) begin
              kind = RSP_TRAP; trap_el = 2'd3;
            end
          end
          2'd2: begin
            if (l3_hit) begin
              kind = RSP_TRAP; trap_el = 2'd3;
            end
          end
          default: kind = RSP_DATA;
        endcase
      end
    end
  end
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         evt,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (cnt_en && evt) begin
      cnt_d  = cnt_q + W'(1);
      cnt_ce = 1'b1;
    end else if (wr_stb && !cnt_en) begin
      cnt_d  = wr_data;
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R10: one step per event edge while enabled
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && evt) |=> (cnt_q == $past(cnt_q) + W'(1)));
  // R10: disabled and not written holds
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_stb) |=> $stable(cnt_q));
  // R11: enabled counter ignores writes
  a_r11_enabled_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !evt) |=> $stable(cnt_q));
endmodule

// File: rtl/evcnt_bank_ctrl.sv
module evcnt_bank_ctrl
  import evcnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_op0,
  input  logic [2:0]         req_op1,
  input  logic [3:0]         req_crn,
  input  logic [3:0]         req_crm,
  input  logic [2:0]         req_op2,
  input  logic [63:0]        req_wdata,
  input  logic [1:0]         cur_el,
  input  logic               cfg_el2_impl,
  input  logic               cfg_el3_impl,
  input  logic               cfg_el2_en,
  input  logic               cfg_user_en,
  input  logic               cfg_route_el2,
  input  logic               cfg_el2_trap,
  input  logic               cfg_el3_trap,
  input  logic [NUM_CNT-1:0] cnt_enable,
  input  logic [NUM_CNT-1:0] cnt_event,
  output logic               rsp_rdata_vld,
  output logic [63:0]        rsp_rdata,
  output logic               rsp_wr_done,
  output logic               rsp_trap,
  output logic [1:0]         rsp_trap_el,
  output logic [5:0]         rsp_trap_ec,
  output logic               rsp_undef
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  logic             bank_hit;
  logic [IDX_W-1:0] cnt_idx;
  rsp_kind_e        kind;
  logic [1:0]       trap_el;
  logic [CNT_W-1:0] cnt_val [SLOTS];

  evcnt_decode u_dec (
    .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
    .bank_hit(bank_hit), .cnt_idx(cnt_idx)
  );

  evcnt_access_resolve u_res (
    .req_valid(req_valid), .bank_hit(bank_hit), .req_write(req_write),
    .cur_el(cur_el), .el2_impl(cfg_el2_impl), .el3_impl(cfg_el3_impl),
    .el2_en(cfg_el2_en), .user_en(cfg_user_en), .route_el2(cfg_route_el2),
    .el2_trap(cfg_el2_trap), .el3_trap(cfg_el3_trap),
    .kind(kind), .trap_el(trap_el)
  );

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      if (g < NUM_CNT) begin : g_cnt
        evcnt_counter #(.W(CNT_W)) u_cnt (
          .clk(clk), .rst_n(rst_n),
          .cnt_en(cnt_enable[g]), .evt(cnt_event[g]),
          .wr_stb((kind == RSP_WDONE) && (cnt_idx == IDX_W'(g))),
          .wr_data(req_wdata), .cnt_q(cnt_val[g])
        );
      end else begin : g_raz
        assign cnt_val[g] = '0;
      end
    end
  endgenerate

  always_comb begin
    rsp_rdata_vld = (kind == RSP_DATA);
    rsp_rdata     = rsp_rdata_vld ? cnt_val[cnt_idx] : '0;
    rsp_wr_done   = (kind == RSP_WDONE);
    rsp_trap      = (kind == RSP_TRAP);
    rsp_trap_el   = trap_el;
    rsp_trap_ec   = rsp_trap ? TRAP_EC : 6'h00;
    rsp_undef     = (kind == RSP_UNDEF);
  end

  // R12: one outcome per targeted request
  a_r12_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bank_hit) |->
      ($countones({rsp_rdata_vld, rsp_wr_done, rsp_trap, rsp_undef}) == 1));
  // R2: nothing raised when not targeted
  a_r2_quiet_off_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && bank_hit) |->
      ($countones({rsp_rdata_vld, rsp_wr_done, rsp_trap, rsp_undef}) == 0));
  // R7: fixed class and an upper target level
  a_r7_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_trap_ec == 6'h18 && rsp_trap_el > cur_el));
  // R8: writes only complete at the top level
  a_r8_write_level: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_done |-> (cfg_el3_impl ? (cur_el == 2'd3)
                   : (cfg_el2_impl ? (cur_el == 2'd2) : (cur_el == 2'd1))));
  // R6: level-3 reads never trap
  a_r6_top_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bank_hit && !req_write && cur_el == 2'd3) |-> rsp_rdata_vld);
  // R9: out-of-range slots read zero
  a_r9_raz: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rdata_vld && ({1'b0, cnt_idx} >= (IDX_W+1)'(NUM_CNT))) |-> (rsp_rdata == '0));
endmodule

// File: tb/test_evcnt_bank_ctrl.sv
module test_evcnt_bank_ctrl;
  localparam int N = 12;
  localparam int K_NONE = 0, K_DATA = 1, K_WR = 2, K_TRAP = 3, K_UNDEF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_op0 = '0; logic [2:0] req_op1 = '0; logic [3:0] req_crn = '0;
  logic [3:0] req_crm = '0; logic [2:0] req_op2 = '0; logic [63:0] req_wdata = '0;
  logic [1:0] cur_el = '0;
  logic cfg_el2_impl = 1'b1, cfg_el3_impl = 1'b1, cfg_el2_en = 1'b0, cfg_user_en = 1'b0;
  logic cfg_route_el2 = 1'b0, cfg_el2_trap = 1'b0, cfg_el3_trap = 1'b0;
  logic [N-1:0] cnt_enable = '0, cnt_event = '0;
  logic rsp_rdata_vld, rsp_wr_done, rsp_trap, rsp_undef;
  logic [63:0] rsp_rdata; logic [1:0] rsp_trap_el; logic [5:0] rsp_trap_ec;

  always #4 clk = ~clk;

  evcnt_bank_ctrl #(.NUM_CNT(N)) i_evcnt_bank_ctrl (.*);

  typedef struct packed { logic [2:0] kind; logic [63:0] data; logic [1:0] el; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic do_req(input bit wr, input logic [1:0] el, input logic [3:0] idx,
                        input logic [63:0] wd, input int kind, input logic [63:0] d,
                        input logic [1:0] tel, input string tag, input bit on_bank = 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; cur_el = el; req_wdata = wd;
    req_op0 = 2'b11; req_op1 = on_bank ? 3'b011 : 3'b010; req_crn = 4'b1101;
    req_crm = {3'b110, idx[3]}; req_op2 = idx[2:0];
    exp_q.push_back('{kind: 3'(kind), data: d, el: tel});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each strobed cycle away from the clock edge
  always @(negedge clk) begin
    #2;
    if (req_valid && exp_q.size() > 0) begin
      exp_t e; string t; logic [3:0] gv, ev; bit bad;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      gv = {rsp_rdata_vld, rsp_wr_done, rsp_trap, rsp_undef};
      ev = {e.kind == 3'(K_DATA), e.kind == 3'(K_WR), e.kind == 3'(K_TRAP), e.kind == 3'(K_UNDEF)};
      bad = (gv != ev);
      if (e.kind == 3'(K_DATA) && rsp_rdata != e.data) bad = 1'b1;
      if (e.kind == 3'(K_TRAP) && (rsp_trap_el != e.el || rsp_trap_ec != 6'h18)) bad = 1'b1;
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s: got flags=%b data=%h el=%0d ec=%h exp flags=%b data=%h el=%0d ec=18",
                 t, gv, rsp_rdata, rsp_trap_el, rsp_trap_ec, ev, e.data, e.el);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    do_req(0, 2'd3, 4'd0, 0, K_DATA, 64'd0, 0, "R1 cnt0 reset");
    do_req(0, 2'd3, 4'd7, 0, K_DATA, 64'd0, 0, "R1 cnt7 reset");
    // R8 and R3: writes at the top level, index from CRm[0]:op2
    do_req(1, 2'd3, 4'd3, 64'h1234_5678_9ABC_DEF0, K_WR, 0, 0, "R8 write top");
    do_req(1, 2'd3, 4'd9, 64'hFFFF_0000_AAAA_5555, K_WR, 0, 0, "R8 write idx9");
    do_req(0, 2'd3, 4'd3, 0, K_DATA, 64'h1234_5678_9ABC_DEF0, 0, "R3 read idx3");
    do_req(0, 2'd3, 4'd9, 0, K_DATA, 64'hFFFF_0000_AAAA_5555, 0, "R3 read idx9");
    do_req(0, 2'd3, 4'd1, 0, K_DATA, 64'd0, 0, "R3 idx1 untouched");
    do_req(1, 2'd1, 4'd3, 64'h1, K_UNDEF, 0, 0, "R8 write el1 undef");
    do_req(1, 2'd0, 4'd3, 64'h1, K_UNDEF, 0, 0, "R8 write el0 undef");
    do_req(0, 2'd3, 4'd3, 0, K_DATA, 64'h1234_5678_9ABC_DEF0, 0, "R8 undef left value");
    // R2 off-bank request
    do_req(0, 2'd3, 4'd3, 0, K_NONE, 0, 0, "R2 off bank", 1'b0);
    // R4 user-enable routing
    cfg_el2_en = 1'b1; cfg_route_el2 = 1'b1;
    do_req(0, 2'd0, 4'd3, 0, K_TRAP, 0, 2'd2, "R4 route el2");
    cfg_route_el2 = 1'b0;
    do_req(0, 2'd0, 4'd3, 0, K_TRAP, 0, 2'd1, "R4 to el1");
    cfg_el2_en = 1'b0; cfg_route_el2 = 1'b1;
    do_req(0, 2'd0, 4'd3, 0, K_TRAP, 0, 2'd1, "R4 el2 off");
    // R5 counter-trap priority at levels 0 and 1
    cfg_route_el2 = 1'b0; cfg_user_en = 1'b1; cfg_el2_en = 1'b1;
    cfg_el2_trap = 1'b1; cfg_el3_trap = 1'b1;
    do_req(0, 2'd0, 4'd3, 0, K_TRAP, 0, 2'd2, "R5 el0 el2 first");
    do_req(0, 2'd1, 4'd3, 0, K_TRAP, 0, 2'd2, "R5 el1 el2 first");
    cfg_el2_en = 1'b0;
    do_req(0, 2'd0, 4'd3, 0, K_TRAP, 0, 2'd3, "R5 el0 el3");
    do_req(0, 2'd1, 4'd3, 0, K_TRAP, 0, 2'd3, "R5 el1 el3");
    cfg_el3_trap = 1'b0;
    do_req(0, 2'd0, 4'd3, 0, K_DATA, 64'h1234_5678_9ABC_DEF0, 0, "R5 el0 data");
    do_req(0, 2'd1, 4'd9, 0, K_DATA, 64'hFFFF_0000_AAAA_5555, 0, "R5 el1 data");
    // R6 level 2 and level 3
    cfg_el2_en = 1'b1;
    do_req(0, 2'd2, 4'd3, 0, K_DATA, 64'h1234_5678_9ABC_DEF0, 0, "R6 el2 ignores el2 trap");
    cfg_el3_trap = 1'b1;
    do_req(0, 2'd2, 4'd3, 0, K_TRAP, 0, 2'd3, "R6 el2 to el3");
    do_req(0, 2'd3, 4'd3, 0, K_DATA, 64'h1234_5678_9ABC_DEF0, 0, "R6 el3 always data");
    // R6/R7: with no level 3 the level-3 trap bit is ignored
    cfg_el3_impl = 1'b0;
    do_req(0, 2'd2, 4'd3, 0, K_DATA, 64'h1234_5678_9ABC_DEF0, 0, "R6 no el3");
    // R8: top level is 2 now
    do_req(1, 2'd2, 4'd5, 64'hABCD, K_WR, 0, 0, "R8 top is el2");
    do_req(0, 2'd2, 4'd5, 0, K_DATA, 64'hABCD, 0, "R8 el2 write landed");
    cfg_el3_impl = 1'b1; cfg_el2_trap = 1'b0; cfg_el3_trap = 1'b0;
    do_req(1, 2'd2, 4'd5, 64'h1, K_UNDEF, 0, 0, "R8 el2 not top");
    // R9 out of range (N=12)
    do_req(1, 2'd3, 4'd13, 64'h77, K_WR, 0, 0, "R9 write oor");
    do_req(0, 2'd3, 4'd13, 0, K_DATA, 64'd0, 0, "R9 read oor");
    do_req(0, 2'd3, 4'd15, 0, K_DATA, 64'd0, 0, "R9 read top slot");
    // R10 counting: counter 2 enabled, counter 4 disabled, both see events
    @(negedge clk);
    cnt_enable[2] = 1'b1; cnt_event[2] = 1'b1; cnt_event[4] = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    cnt_event = '0;
    do_req(0, 2'd3, 4'd2, 0, K_DATA, 64'd5, 0, "R10 five events");
    do_req(0, 2'd3, 4'd4, 0, K_DATA, 64'd0, 0, "R10 disabled holds");
    // R11 write to enabled counter ignored
    do_req(1, 2'd3, 4'd2, 64'h999, K_WR, 0, 0, "R11 write enabled");
    do_req(0, 2'd3, 4'd2, 0, K_DATA, 64'd5, 0, "R11 value kept");
    // R10 wrap: preload disabled counter 6 near max then count twice
    do_req(1, 2'd3, 4'd6, 64'hFFFF_FFFF_FFFF_FFFF, K_WR, 0, 0, "R10 preload max");
    @(negedge clk);
    cnt_enable[6] = 1'b1; cnt_event[6] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cnt_event = '0;
    do_req(0, 2'd3, 4'd6, 0, K_DATA, 64'd1, 0, "R10 wrap");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule